// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block moves words from a write clock domain to an unrelated read clock domain through a power-of-two memory. Besides full and empty, it drives two active-low threshold flags: one that warns when few words remain stored, and one that warns when little free space remains. Each threshold is set by an offset register. Both offsets take default values at reset and can be reloaded through a small parallel load port while no traffic is flowing.

Two straps are sampled while reset is held. The read-mode strap picks one of two read modes. In the registered mode, a read enable pulls the next word onto the output. In the look-ahead mode, the oldest word is already shown on the output before it is read, and that output register adds one word of capacity. The flag-timing strap picks how the flags are produced. In the clocked style, each flag is registered in its own domain from pointers that crossed over in Gray code through two-flop synchronizers. In the immediate style, each flag is decoded directly from both raw pointers: the edge in one domain sets it, and the edge in the other domain clears it, with no synchronizer delay.

Top module: `dcf_fifo`

## Requirements
- R1: After reset, empty_o is 1, full_o is 0, almost_empty_no is 0 and almost_full_no is 1, in either mode.
- R2: Words leave in the order they were accepted, with their values unchanged, in both read modes.
- R3: A write while full_o is 1 stores nothing and leaves the stored words and their order unchanged.
- R4: A read while empty_o is 1 moves no pointer. In registered mode, rdata_o keeps its previous value. A word written afterwards is the next one read.
- R5: In registered mode (read-mode strap 0), capacity is DEPTH words. full_o is 1 exactly when DEPTH words are stored. rdata_o changes only after a read enable.
- R6: In look-ahead mode (read-mode strap 1), capacity is DEPTH+1 words. The oldest word is present on rdata_o with empty_o at 0 before any read enable, and a read enable removes it.
- R7: In registered mode, with almost-empty offset n, almost_empty_no is 0 when n or fewer words are stored and 1 when n+1 or more are stored.
- R8: In look-ahead mode, almost_empty_no is 0 when n+1 or fewer words are stored and 1 when n+2 or more are stored.
- R9: With almost-full offset m and mode capacity C (R5, R6), almost_full_no is 0 when C−m or more words are stored and 1 otherwise.
- R10: Both straps are sampled only while rst_ni is 0. Changing them after reset has no effect.
- R11: With the flag-timing strap at 0 (immediate), almost_empty_no rises within the write clock cycle of the write that crosses its threshold. almost_full_no rises within the read clock cycle of the read that crosses its threshold.
- R12: With the flag-timing strap at 1 (clocked), almost_empty_no does not change in the write clock cycle of the crossing write. It rises only after the write pointer has passed the read-domain synchronizer, and then settles to the R7/R8 value.
- R13: Reset loads the almost-empty offset DEF_AE_OFF and the almost-full offset DEF_AF_OFF, both 2 by default. A write-clock cycle with off_we_i at 1 loads off_val_i into the almost-empty offset when off_sel_i is 0, and into the almost-full offset when off_sel_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write domain clock |
| rd_clk_i | input | 1 | Read domain clock |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| mode_look_ahead_i | input | 1 | Read-mode strap, sampled during reset: 1 = look-ahead |
| flag_clocked_i | input | 1 | Flag-timing strap, sampled during reset: 1 = clocked, 0 = immediate |
| wr_en_i | input | 1 | Write enable |
| wdata_i | input | DATA_W | Write data |
| full_o | output | 1 | Memory full, writes ignored |
| almost_full_no | output | 1 | Active-low almost-full flag |
| rd_en_i | input | 1 | Read enable |
| rdata_o | output | DATA_W | Read data register |
| empty_o | output | 1 | No word available, reads ignored |
| almost_empty_no | output | 1 | Active-low almost-empty flag |
| off_we_i | input | 1 | Offset load strobe (write clock) |
| off_sel_i | input | 1 | Offset select: 0 almost-empty, 1 almost-full |
| off_val_i | input | ADDR_W+1 | Offset value to load |

## Verification
The bench walks the stored count through every value from zero to capacity and back. It does this in both read modes, with default and reloaded offsets. A flag threshold that is off by one, or that ignores the one-word shift of look-ahead mode, shows up at the exact count where it fails. It writes into a full FIFO and reads from an empty one. A design that moves a pointer on those cycles then loses or repeats a word, and the scoreboard reports it. It samples the flags one nanosecond after the crossing edge. An immediate-style flag that waited for a synchronizer, or a clocked-style flag that bypassed one, shows up as the wrong level. It flips the straps after reset. A design that samples them continuously then changes its read behaviour.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {RD_REGISTERED = 1'b0, RD_LOOK_AHEAD = 1'b1} rd_mode_e;
  typedef enum logic {FLAG_IMMEDIATE = 1'b0, FLAG_CLOCKED = 1'b1} flag_mode_e;
endpackage

// File: rtl/dcf_ptr_xing.sv
module dcf_ptr_xing #(
  parameter int W = 5
) (
  input  logic         src_clk_i,
  input  logic         dst_clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] gray_q, s1_q, s2_q;

  always_ff @(posedge src_clk_i or negedge rst_ni)
    if (!rst_ni) gray_q <= '0;
    else         gray_q <= bin_i ^ (bin_i >> 1);

  always_ff @(posedge dst_clk_i or negedge rst_ni)
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_q;
      s2_q <= s1_q;
    end

  always_comb
    for (int i = 0; i < W; i++) bin_o[i] = ^(s2_q >> i);

  AST_GRAY_STEP: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    $onehot0(gray_q ^ $past(gray_q))) else $error("gray step"); // R12
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i)
    if (we_i) mem_q[waddr_i] <= wdata_i;

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
  import dcf_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 4,
  parameter int DEF_AE_OFF = 2,
  parameter int DEF_AF_OFF = 2
) (
  input  logic              wr_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic              mode_look_ahead_i,
  input  logic              flag_clocked_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              full_o,
  output logic              almost_full_no,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_o,
  output logic              almost_empty_no,
  input  logic              off_we_i,
  input  logic              off_sel_i,
  input  logic [ADDR_W:0]   off_val_i
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

  // straps: captured on each domain's clock while reset is held
  flag_mode_e flag_w_q, flag_r_q;
  rd_mode_e   rmode_r_q;

  always_ff @(posedge wr_clk_i)
    if (!rst_ni) flag_w_q <= flag_mode_e'(flag_clocked_i);

  always_ff @(posedge rd_clk_i)
    if (!rst_ni) begin
      flag_r_q  <= flag_mode_e'(flag_clocked_i);
      rmode_r_q <= rd_mode_e'(mode_look_ahead_i);
    end

  // ---------------- write domain ----------------
  logic [PTR_W-1:0] wptr_q, wptr_nxt, rptr_w, wcnt, wcnt_nxt;
  logic [PTR_W-1:0] ae_off_q, af_off_q;
  logic             wr_ok, af_n_q;

  assign wcnt     = wptr_q - rptr_w;
  assign full_o   = (wcnt == DEPTH_P);
  assign wr_ok    = wr_en_i && !full_o;
  assign wptr_nxt = wptr_q + PTR_W'(wr_ok);
  assign wcnt_nxt = wptr_nxt - rptr_w;

  always_ff @(posedge wr_clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wptr_q   <= '0;
      af_n_q   <= 1'b1;
      ae_off_q <= PTR_W'(DEF_AE_OFF);
      af_off_q <= PTR_W'(DEF_AF_OFF);
    end else begin
      wptr_q <= wptr_nxt;
      af_n_q <= !(wcnt_nxt >= DEPTH_P - af_off_q);
      if (off_we_i) begin
        if (off_sel_i) af_off_q <= off_val_i;
        else           ae_off_q <= off_val_i;
      end
    end

  // ---------------- read domain -----------------
  logic [PTR_W-1:0]  rptr_q, rptr_nxt, wptr_r, rcnt, rcnt_nxt;
  logic [DATA_W-1:0] mem_rdata, dout_q;
  logic              mem_empty, ld, oval_q, ae_n_q;

  assign rcnt      = wptr_r - rptr_q;
  assign mem_empty = (rcnt == '0);
  assign ld        = (rmode_r_q == RD_LOOK_AHEAD) ? (!mem_empty && (!oval_q || rd_en_i))
                                                  : (rd_en_i && !mem_empty);
  assign rptr_nxt  = rptr_q + PTR_W'(ld);
  assign rcnt_nxt  = wptr_r - rptr_nxt;

  always_ff @(posedge rd_clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rptr_q <= '0;
      dout_q <= '0;
      oval_q <= 1'b0;
      ae_n_q <= 1'b0;
    end else begin
      rptr_q <= rptr_nxt;
      ae_n_q <= rcnt_nxt > ae_off_q;
      if (ld) dout_q <= mem_rdata;
      if (rmode_r_q == RD_LOOK_AHEAD) begin
        if (ld)           oval_q <= 1'b1;
        else if (rd_en_i) oval_q <= 1'b0;
      end
    end

  assign rdata_o = dout_q;
  assign empty_o = (rmode_r_q == RD_LOOK_AHEAD) ? !oval_q : mem_empty;

  // immediate flags decode both raw pointers across the domains
  logic [PTR_W-1:0] raw_cnt;
  assign raw_cnt = wptr_q - rptr_q;

  assign almost_full_no  = (flag_w_q == FLAG_CLOCKED) ? af_n_q
                         : !(raw_cnt >= DEPTH_P - af_off_q);
  assign almost_empty_no = (flag_r_q == FLAG_CLOCKED) ? ae_n_q
                         : (raw_cnt > ae_off_q);

  // ---------------- submodules ------------------
  dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk_i  (wr_clk_i),
    .we_i   (wr_ok),
    .waddr_i(wptr_q[ADDR_W-1:0]),
    .wdata_i(wdata_i),
    .raddr_i(rptr_q[ADDR_W-1:0]),
    .rdata_o(mem_rdata)
  );

  dcf_ptr_xing #(.W(PTR_W)) u_w2r (
    .src_clk_i(wr_clk_i), .dst_clk_i(rd_clk_i), .rst_ni(rst_ni),
    .bin_i(wptr_q), .bin_o(wptr_r)
  );

  dcf_ptr_xing #(.W(PTR_W)) u_r2w (
    .src_clk_i(rd_clk_i), .dst_clk_i(wr_clk_i), .rst_ni(rst_ni),
    .bin_i(rptr_q), .bin_o(rptr_w)
  );

  // ---------------- assertions ------------------
  AST_NO_OVERFLOW: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    wcnt <= DEPTH_P) else $error("overflow"); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    rcnt <= DEPTH_P) else $error("underflow"); // R4
  AST_WPTR_STEP: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (wptr_q == $past(wptr_q)) || (wptr_q == $past(wptr_q) + PTR_W'(1))) else $error("wptr step"); // R2
  AST_EMPTY_HOLD: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (rmode_r_q == RD_REGISTERED && empty_o && rd_en_i) |=> $stable(rdata_o)) else $error("empty read"); // R4
  AST_LOOK_AHEAD_HOLD: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (rmode_r_q == RD_LOOK_AHEAD && !empty_o && !rd_en_i) |=> $stable(rdata_o)) else $error("head moved"); // R6
endmodule

// File: tb/dcf_fifo_tb.sv
`timescale 1ns/1ps
module dcf_fifo_tb;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic la_sel = 0, clk_sel = 1;
  logic wr_en = 0, rd_en = 0, off_we = 0, off_sel = 0;
  logic [DW-1:0] wdata = '0;
  logic [AW:0] off_val = '0;
  logic full, af_n, empty, ae_n;
  logic [DW-1:0] rdata;

  always #2 wr_clk = ~wr_clk;   // 250 MHz
  always #3 rd_clk = ~rd_clk;

  dcf_fifo #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_n),
    .mode_look_ahead_i(la_sel), .flag_clocked_i(clk_sel),
    .wr_en_i(wr_en), .wdata_i(wdata), .full_o(full), .almost_full_no(af_n),
    .rd_en_i(rd_en), .rdata_o(rdata), .empty_o(empty), .almost_empty_no(ae_n),
    .off_we_i(off_we), .off_sel_i(off_sel), .off_val_i(off_val)
  );

  logic [DW-1:0] sb[$];
  int n_chk = 0, n_bad = 0, cnt = 0, ae_off = 2, af_off = 2, la = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(bit l, bit c);
    rst_n = 0; la_sel = l; clk_sel = c; wr_en = 0; rd_en = 0; off_we = 0;
    repeat (6) @(posedge rd_clk);
    @(negedge wr_clk) rst_n = 1;
    cnt = 0; sb.delete(); ae_off = 2; af_off = 2; la = l;
    repeat (4) @(negedge rd_clk);
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
  endtask

  function automatic int cap();
    return DEPTH + la;
  endfunction

  task automatic wr(logic [DW-1:0] d);
    @(negedge wr_clk) begin wr_en = 1; wdata = d; end
    @(negedge wr_clk) wr_en = 0;
    if (cnt < cap()) begin sb.push_back(d); cnt++; end
  endtask

  task automatic check_state();
    @(negedge wr_clk);
    chk(empty == (cnt == 0), la ? "R6" : "R5", "empty", empty, cnt == 0);
    chk(full == (cnt == cap()), la ? "R6" : "R5", "full", full, cnt == cap());
    chk(ae_n == (cnt > ae_off + la), la ? "R8" : "R7", $sformatf("almost_empty_n cnt=%0d", cnt),
        ae_n, cnt > ae_off + la);
    chk(af_n == !(cnt >= cap() - af_off), "R9", $sformatf("almost_full_n cnt=%0d", cnt),
        af_n, !(cnt >= cap() - af_off));
    if (la && cnt > 0) chk(rdata == sb[0], "R6", "head word shown", rdata, sb[0]);
  endtask

  task automatic rd_chk();
    logic [DW-1:0] e;
    e = sb.pop_front(); cnt--;
    if (la) begin
      @(negedge wr_clk) chk(rdata == e, "R2", "look-ahead data", rdata, e);
      @(negedge rd_clk) rd_en = 1;
      @(negedge rd_clk) rd_en = 0;
    end else begin
      @(negedge rd_clk) rd_en = 1;
      @(negedge rd_clk) rd_en = 0;
      @(negedge wr_clk) chk(rdata == e, "R2", "registered data", rdata, e);
    end
  endtask

  task automatic fill_drain(logic [DW-1:0] base);
    for (int i = 0; i <= cap(); i++) begin
      wr(base + DW'(i));
      settle();
      check_state();
    end
    chk(full == 1, "R3", "still full after extra write", full, 1);
    while (cnt > 0) begin
      rd_chk();
      settle();
      check_state();
    end
  endtask

  task automatic empty_read_test();
    logic [DW-1:0] last;
    @(negedge wr_clk) last = rdata;
    @(negedge rd_clk) rd_en = 1;
    @(negedge rd_clk) rd_en = 0;
    settle();
    @(negedge wr_clk);
    chk(empty == 1, "R4", "empty after empty read", empty, 1);
    if (!la) chk(rdata == last, "R4", "data kept on empty read", rdata, last);
    wr(8'h3C); settle();
    rd_chk(); settle();
    chk(empty == 1, "R4", "empty after recovery read", empty, 1);
  endtask

  task automatic wr_peek(logic [DW-1:0] d, output logic ae_s);
    @(negedge wr_clk) begin wr_en = 1; wdata = d; end
    @(posedge wr_clk); #1 ae_s = ae_n;
    @(negedge wr_clk) wr_en = 0;
    sb.push_back(d); cnt++;
  endtask

  initial begin
    logic s;
    // R1 reset, registered mode, clocked flags
    do_reset(0, 1);
    @(negedge wr_clk);
    chk(empty == 1, "R1", "empty", empty, 1);
    chk(full == 0, "R1", "full", full, 0);
    chk(ae_n == 0, "R1", "almost_empty_n", ae_n, 0);
    chk(af_n == 1, "R1", "almost_full_n", af_n, 1);

    // R10 strap changes after reset are ignored
    la_sel = 1; clk_sel = 0;
    wr(8'hA5); settle();
    @(negedge wr_clk) chk(rdata == 0, "R10", "no look-ahead after strap flip", rdata, 0);
    wr(8'h01); wr(8'h02); wr(8'h03);
    @(negedge wr_clk) chk(ae_n == 0, "R10", "flags still clocked", ae_n, 0);
    settle();
    la_sel = 0; clk_sel = 1;
    while (cnt > 0) begin rd_chk(); settle(); end

    fill_drain(8'h40);          // R5 R7 R9 R3 R2
    empty_read_test();          // R4

    // R13 reloaded offsets
    @(negedge wr_clk) begin off_we = 1; off_sel = 0; off_val = 4; end
    @(negedge wr_clk) begin off_sel = 1; off_val = 3; end
    @(negedge wr_clk) off_we = 0;
    ae_off = 4; af_off = 3;
    for (int i = 0; i < 5; i++) begin wr(8'h70 + DW'(i)); settle(); end
    @(negedge wr_clk) chk(ae_n == 1, "R13", "ae at n+1 with n=4", ae_n, 1);
    rd_chk(); settle();
    @(negedge wr_clk) chk(ae_n == 0, "R13", "ae at n with n=4", ae_n, 0);
    while (cnt > 0) begin rd_chk(); settle(); end
    fill_drain(8'h80);

    // look-ahead mode
    do_reset(1, 1);
    @(negedge wr_clk) chk(empty == 1 && ae_n == 0 && af_n == 1 && full == 0, "R1",
                          "look-ahead reset flags", {empty, ae_n, af_n, full}, 4'b1010);
    wr(8'h11); settle();
    @(negedge wr_clk) chk(rdata == 8'h11 && empty == 0, "R6", "first word shown",
                          rdata, 8'h11);
    rd_chk(); settle();
    fill_drain(8'hC0);          // R6 R8 R9 R3 R2
    empty_read_test();          // R4

    // R11 immediate flags
    do_reset(0, 0);
    wr(8'h21); wr(8'h22); settle();
    wr_peek(8'h23, s);
    chk(s == 1, "R11", "ae rises in write cycle", s, 1);
    for (int i = 0; i < 11; i++) wr(8'h30 + DW'(i));
    settle();
    @(negedge wr_clk) chk(af_n == 0, "R11", "af low at C-m", af_n, 0);
    @(negedge rd_clk) rd_en = 1;
    @(posedge rd_clk); #1 s = af_n;
    @(negedge rd_clk) rd_en = 0;
    void'(sb.pop_front()); cnt--;
    chk(s == 1, "R11", "af rises in read cycle", s, 1);
    while (cnt > 0) begin rd_chk(); settle(); end

    // R12 clocked flags
    do_reset(0, 1);
    wr(8'h51); wr(8'h52); settle();
    wr_peek(8'h53, s);
    chk(s == 0, "R12", "ae not yet risen in write cycle", s, 0);
    settle();
    @(negedge wr_clk) chk(ae_n == 1, "R12", "ae risen after sync", ae_n, 1);
    while (cnt > 0) begin rd_chk(); settle(); end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired (all requirements)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule